// File: doc/BRIEF.md
# Ultra DMA Data-In Host Receiver

This block is the host side of a source-synchronous read burst from a storage device. When software arms a read and the device raises its DMA request, the block waits out the acknowledge setup time and asserts the active-low acknowledge. It then drives its active-low ready line and captures one 16-bit word on every rising and every falling edge of the device strobe. Strobe, data and request are first brought into the host clock domain through a synchronizer. Each captured word goes straight to the write port of a downstream FIFO.

The ready line is negated whenever the FIFO reports three or fewer free entries, or when the host asks to stop. After a host stop request the block negates ready, waits the ready-to-pause time and then asserts STOP. It keeps accepting any words that the device sends after ready was negated. A burst ends when the device drops its request or when the host has asserted STOP and the device then drops its request. After the acknowledge hold time the block releases acknowledge and gives a one-cycle report with the word count and which side ended the burst. All timing values are parameters counted in host clock cycles for one chosen transfer mode.

Top module: `udma_rx_host`

## Requirements
- R1: After reset and while no burst runs, `dmack_n` is 1, `stop_o` is 0, `hrdy_n` is 1 and `fifo_wr_en` is 0.
- R2: `dmack_n` goes low only when `rx_enable` is 1 and `dmarq` is 1. With `rx_enable` at 0, a raised `dmarq` leaves `dmack_n` at 1.
- R3: While a burst is live, every rising edge and every falling edge of `dstrobe` produces exactly one `fifo_wr_en` pulse. `fifo_wr_data` carries the `dd` value that came with that edge, in arrival order.
- R4: Strobe edges that occur while `dmack_n` is 1 produce no FIFO write.
- R5: During transfer `hrdy_n` is 0 when `fifo_free` is greater than 3, and it is 1 when `fifo_free` is 3 or less.
- R6: On a host stop request, `hrdy_n` is negated first. `stop_o` rises no sooner than T_RP_CYC cycles (default 16) after that.
- R7: Words that arrive after `hrdy_n` is negated, and before the burst closes, are still written to the FIFO.
- R8: When the device drops `dmarq` during transfer, `stop_o` rises while `dmack_n` is still 0.
- R9: `dmack_n` returns to 1 only while `dmarq` is 0, and `stop_o` is never 1 while `dmack_n` is 1.
- R10: At the end of each burst `done_pulse` is 1 for exactly one cycle. `done_words` then holds the number of words written in that burst, and `done_by_host` is 1 for a host-ended burst and 0 for a device-ended burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Host has armed a read transfer |
| host_stop_req | input | 1 | Host asks to end the running burst |
| dmarq | input | 1 | Device DMA request, active high, asynchronous |
| dstrobe | input | 1 | Device data strobe, asynchronous |
| dd | input | 16 | Device data bus |
| fifo_free | input | 6 | Free entries in the downstream FIFO |
| dmack_n | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | STOP line to the device |
| hrdy_n | output | 1 | Host ready line, active low |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 16 | FIFO write data |
| done_pulse | output | 1 | One-cycle end-of-burst report |
| done_words | output | 16 | Words received in the finished burst |
| done_by_host | output | 1 | 1 if the host ended the burst |

## Verification
The checker watches several relations on every cycle. It confirms that the ready line is negated whenever the FIFO is nearly full during acknowledge, and that no write happens outside acknowledge. It also confirms that STOP is never raised without acknowledge, that acknowledge is taken only under request and enable and released only with request low, that a host-initiated STOP comes at least the ready-to-pause time after ready was negated, and that the end report lasts one cycle. Other behaviours can only be shown by the bench scenarios: word order and content across both strobe edges, acceptance of late words after a pause, the exact count and origin of each ended burst, and the absence of writes from strobe activity before a burst.

// File: rtl/udma_rx_pkg.sv
// Shared types for the data-in burst receiver.
package udma_rx_pkg;
    // Burst controller states, in the order a burst walks through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_SETUP,
        ST_ACTIVE,
        ST_PAUSE,
        ST_STOP,
        ST_DEV_END,
        ST_ACK_HOLD
    } burst_st_t;
endpackage

// File: rtl/udma_rx_capture.sv
// Brings the device strobe, data and request into the host clock domain.
// It emits a write for every strobe transition while the burst is live.
// Assumes the data is stable from its strobe edge until the next edge, and
// that the strobe half-period spans several host clocks.
module udma_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] dd,
    input  logic              dmarq,
    input  logic              burst_live,
    output logic              dmarq_s,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    logic              s1, s2, s3;
    logic [DATA_W-1:0] d1, d2;
    logic              r1, r2;

    // Strobe synchronizer plus one stage for edge detection; idle level high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= strobe;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Data pipeline of the same depth so each word lines up with its edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1 <= '0;
            d2 <= '0;
        end else begin
            d1 <= dd;
            d2 <= d1;
        end
    end

    // Request synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1 <= 1'b0;
            r2 <= 1'b0;
        end else begin
            r1 <= dmarq;
            r2 <= r1;
        end
    end

    assign dmarq_s = r2;
    assign wr_en   = (s2 ^ s3) & burst_live;
    assign wr_data = d2;
endmodule

// File: rtl/udma_rx_fsm.sv
// Burst sequencer for the handshake lines: acknowledge setup and hold, the
// ready line with its FIFO threshold, the pause-then-stop host termination
// and the device termination path. Timing values are in host clock cycles
// and each must be at least 1.
module udma_rx_fsm
    import udma_rx_pkg::*;
#(
    parameter int FREE_W      = 6,
    parameter int FULL_THRESH = 3,
    parameter int T_ACK_CYC   = 2,
    parameter int T_RP_CYC    = 16,
    parameter int T_MLI_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              host_stop_req,
    input  logic              dmarq_s,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              dmack_n,
    output logic              stop_o,
    output logic              hrdy_n,
    output logic              burst_live,
    output logic              burst_start,
    output logic              burst_end,
    output logic              end_by_host
);
    localparam int MAX_A = (T_ACK_CYC > T_RP_CYC) ? T_ACK_CYC : T_RP_CYC;
    localparam int MAX_T = (MAX_A > T_MLI_CYC) ? MAX_A : T_MLI_CYC;
    localparam int TMR_W = $clog2(MAX_T + 1);
    localparam logic [TMR_W-1:0] LD_ACK = TMR_W'(T_ACK_CYC - 1);
    localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_MLI = TMR_W'(T_MLI_CYC - 1);

    burst_st_t        state, nxt;
    logic [TMR_W-1:0] tmr, tmr_nxt;
    logic             by_host, by_host_nxt;

    // State, wait timer and termination origin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            by_host <= 1'b0;
        end else begin
            state   <= nxt;
            tmr     <= tmr_nxt;
            by_host <= by_host_nxt;
        end
    end

    // Next-state and timer reload logic.
    always_comb begin
        nxt         = state;
        tmr_nxt     = tmr;
        by_host_nxt = by_host;
        case (state)
            ST_IDLE: begin
                if (rx_enable && dmarq_s && !host_stop_req) begin
                    nxt     = ST_ACK_SETUP;
                    tmr_nxt = LD_ACK;
                end
            end
            ST_ACK_SETUP: begin
                if (!dmarq_s)       nxt = ST_IDLE;
                else if (tmr == '0) nxt = ST_ACTIVE;
                else                tmr_nxt = tmr - 1'b1;
            end
            ST_ACTIVE: begin
                if (!dmarq_s) begin
                    nxt     = ST_DEV_END;
                    tmr_nxt = LD_MLI;
                end else if (host_stop_req) begin
                    nxt     = ST_PAUSE;
                    tmr_nxt = LD_RP;
                end
            end
            ST_PAUSE: begin
                if (!dmarq_s) begin
                    nxt     = ST_DEV_END;
                    tmr_nxt = LD_MLI;
                end else if (tmr == '0) begin
                    nxt = ST_STOP;
                end else begin
                    tmr_nxt = tmr - 1'b1;
                end
            end
            ST_STOP: begin
                if (!dmarq_s) begin
                    nxt         = ST_ACK_HOLD;
                    tmr_nxt     = LD_ACK;
                    by_host_nxt = 1'b1;
                end
            end
            ST_DEV_END: begin
                if (tmr == '0) begin
                    nxt         = ST_ACK_HOLD;
                    tmr_nxt     = LD_ACK;
                    by_host_nxt = 1'b0;
                end else begin
                    tmr_nxt = tmr - 1'b1;
                end
            end
            ST_ACK_HOLD: begin
                if (tmr == '0) nxt = ST_IDLE;
                else           tmr_nxt = tmr - 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Line decode from the registered state.
    always_comb begin
        burst_live  = state inside {ST_ACTIVE, ST_PAUSE, ST_STOP, ST_DEV_END};
        dmack_n     = !(burst_live || state == ST_ACK_HOLD);
        stop_o      = (state == ST_STOP) || (state == ST_ACK_HOLD);
        hrdy_n      = !((state == ST_ACTIVE) &&
                        (fifo_free > FREE_W'(FULL_THRESH)));
        burst_start = (state == ST_ACK_SETUP) && (nxt == ST_ACTIVE);
        burst_end   = (state == ST_ACK_HOLD) && (tmr == '0);
        end_by_host = by_host;
    end
endmodule

// File: rtl/udma_rx_tally.sv
// Counts the words written in the current burst and issues the end report.
// Assumes the start and end strobes never coincide with a write.
module udma_rx_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic             finish,
    input  logic             by_host_in,
    output logic             done_pulse,
    output logic [CNT_W-1:0] done_words,
    output logic             done_by_host
);
    logic [CNT_W-1:0] count;

    // Running word count for the burst in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    // One-cycle report, with the result held until the next burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse   <= 1'b0;
            done_words   <= '0;
            done_by_host <= 1'b0;
        end else begin
            done_pulse <= finish;
            if (finish) begin
                done_words   <= count;
                done_by_host <= by_host_in;
            end
        end
    end
endmodule

// File: rtl/udma_rx_host.sv
// Top of the data-in burst receiver. It joins the clock-domain capture, the
// handshake sequencer and the word tally. FIFO writes are issued without
// backpressure, since the ready threshold leaves room for late words.
module udma_rx_host #(
    parameter int DATA_W      = 16,
    parameter int FREE_W      = 6,
    parameter int CNT_W       = 16,
    parameter int FULL_THRESH = 3,
    parameter int T_ACK_CYC   = 2,
    parameter int T_RP_CYC    = 16,
    parameter int T_MLI_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              host_stop_req,
    input  logic              dmarq,
    input  logic              dstrobe,
    input  logic [DATA_W-1:0] dd,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              dmack_n,
    output logic              stop_o,
    output logic              hrdy_n,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              done_pulse,
    output logic [CNT_W-1:0]  done_words,
    output logic              done_by_host
);
    logic dmarq_s, burst_live, burst_start, burst_end, end_by_host;

    udma_rx_capture #(.DATA_W(DATA_W)) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (dstrobe),
        .dd         (dd),
        .dmarq      (dmarq),
        .burst_live (burst_live),
        .dmarq_s    (dmarq_s),
        .wr_en      (fifo_wr_en),
        .wr_data    (fifo_wr_data)
    );

    udma_rx_fsm #(
        .FREE_W      (FREE_W),
        .FULL_THRESH (FULL_THRESH),
        .T_ACK_CYC   (T_ACK_CYC),
        .T_RP_CYC    (T_RP_CYC),
        .T_MLI_CYC   (T_MLI_CYC)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_enable     (rx_enable),
        .host_stop_req (host_stop_req),
        .dmarq_s       (dmarq_s),
        .fifo_free     (fifo_free),
        .dmack_n       (dmack_n),
        .stop_o        (stop_o),
        .hrdy_n        (hrdy_n),
        .burst_live    (burst_live),
        .burst_start   (burst_start),
        .burst_end     (burst_end),
        .end_by_host   (end_by_host)
    );

    udma_rx_tally #(.CNT_W(CNT_W)) tally_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (burst_start),
        .inc          (fifo_wr_en),
        .finish       (burst_end),
        .by_host_in   (end_by_host),
        .done_pulse   (done_pulse),
        .done_words   (done_words),
        .done_by_host (done_by_host)
    );
endmodule

// File: rtl/udma_rx_host_chk.sv
// Protocol checker for the data-in receiver, bound to the top module.
// The pause window is measured with a saturating counter, not a deep $past.
module udma_rx_host_chk #(
    parameter int FREE_W      = 6,
    parameter int FULL_THRESH = 3,
    parameter int T_RP_CYC    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              dmarq,
    input logic [FREE_W-1:0] fifo_free,
    input logic              dmack_n,
    input logic              stop_o,
    input logic              hrdy_n,
    input logic              fifo_wr_en,
    input logic              done_pulse
);
    localparam int HW = $clog2(T_RP_CYC + 2);
    logic [HW-1:0] hi_cnt;

    // Consecutive cycles with the ready line negated, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_cnt <= '0;
        else if (!hrdy_n)                    hi_cnt <= '0;
        else if (hi_cnt != HW'(T_RP_CYC))    hi_cnt <= hi_cnt + 1'b1;
    end

    AST_RDY_NEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmack_n && fifo_free <= FREE_W'(FULL_THRESH)) |-> hrdy_n); // R5
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dmack_n |-> !fifo_wr_en); // R4
    AST_STOP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !dmack_n); // R9
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n) |-> !dmarq); // R9
    AST_ACK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n) |-> (rx_enable && dmarq)); // R2
    AST_PAUSE_BEFORE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_o) && dmarq) |-> (hrdy_n && hi_cnt >= HW'(T_RP_CYC))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R10
endmodule

bind udma_rx_host udma_rx_host_chk #(
    .FREE_W      (FREE_W),
    .FULL_THRESH (FULL_THRESH),
    .T_RP_CYC    (T_RP_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .dmarq      (dmarq),
    .fifo_free  (fifo_free),
    .dmack_n    (dmack_n),
    .stop_o     (stop_o),
    .hrdy_n     (hrdy_n),
    .fifo_wr_en (fifo_wr_en),
    .done_pulse (done_pulse)
);

// File: tb/udma_rx_host_tb_top.sv
// Scoreboard bench: the device-side driver queues each word it sends, and a
// monitor pops and compares them as the FIFO writes appear.
module udma_rx_host_tb_top;
    localparam int T_RP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0, host_stop_req = 1'b0, dmarq = 1'b0;
    logic        dstrobe = 1'b1;
    logic [15:0] dd = '0;
    logic [5:0]  fifo_free = 6'd40;
    logic        dmack_n, stop_o, hrdy_n, fifo_wr_en, done_pulse, done_by_host;
    logic [15:0] fifo_wr_data, done_words;

    int          checks = 0, errors = 0, wr_count = 0;
    logic [15:0] exp_q[$];
    logic        done_flag = 1'b0;
    logic [15:0] got_words;
    logic        got_by_host;

    always #5 clk = ~clk;

    udma_rx_host dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .host_stop_req(host_stop_req), .dmarq(dmarq), .dstrobe(dstrobe),
        .dd(dd), .fifo_free(fifo_free), .dmack_n(dmack_n), .stop_o(stop_o),
        .hrdy_n(hrdy_n), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .done_pulse(done_pulse), .done_words(done_words),
        .done_by_host(done_by_host)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Device driver: put a word on the bus with a strobe transition.
    task automatic send_word(input logic [15:0] w);
        exp_q.push_back(w);
        dd      = w;
        dstrobe = ~dstrobe;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_ack();
        while (dmack_n) @(negedge clk);
    endtask

    // Monitor: compare each FIFO write and capture end reports.
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            wr_count++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected write actual=%0h expected=none",
                         fifo_wr_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (fifo_wr_data !== e) begin
                    errors++;
                    $display("FAIL R3 word actual=%0h expected=%0h",
                             fifo_wr_data, e);
                end
            end
        end
        if (rst_n && done_pulse) begin
            done_flag   = 1'b1;
            got_words   = done_words;
            got_by_host = done_by_host;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int gap, wc0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dmack_n", dmack_n, 1);
        check("R1 stop_o", stop_o, 0);
        check("R1 hrdy_n", hrdy_n, 1);
        check("R1 wr_en", fifo_wr_en, 0);

        // R4: strobe activity with no burst writes nothing.
        wc0 = wr_count;
        for (int i = 0; i < 4; i++) begin
            dd = 16'hDEAD; dstrobe = ~dstrobe; repeat (4) @(negedge clk);
        end
        check("R4 idle writes", wr_count - wc0, 0);

        // R2: request without enable is not acknowledged.
        dmarq = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 no ack without enable", dmack_n, 1);
        dmarq = 1'b0;
        repeat (4) @(negedge clk);

        // Burst 1: device-ended, with a near-full FIFO excursion.
        done_flag = 1'b0;
        rx_enable = 1'b1; dmarq = 1'b1;
        wait_ack();
        check("R2 ack under enable", dmack_n, 0);
        check("R5 ready with room", hrdy_n, 0);
        check("R9 stop low at start", stop_o, 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) send_word(16'hA500 + 16'(i * 16'h0111));
        fifo_free = 6'd3;
        @(negedge clk);
        check("R5 ready off at 3 free", hrdy_n, 1);
        for (int i = 4; i < 6; i++) send_word(16'hA500 + 16'(i * 16'h0111));
        fifo_free = 6'd4;
        @(negedge clk);
        check("R5 ready on at 4 free", hrdy_n, 0);
        fifo_free = 6'd40;
        for (int i = 6; i < 8; i++) send_word(16'hA500 + 16'(i * 16'h0111));
        repeat (6) @(negedge clk);
        dmarq = 1'b0;
        while (!stop_o) @(negedge clk);
        check("R8 stop while ack held", dmack_n, 0);
        while (!done_flag) @(negedge clk);
        check("R10 words dev end", got_words, 8);
        check("R10 origin dev end", got_by_host, 0);
        check("R9 ack released", dmack_n, 1);
        check("R3 queue drained", exp_q.size(), 0);
        rx_enable = 1'b0;
        repeat (4) @(negedge clk);

        // Burst 2: host pause then stop, with late words.
        done_flag = 1'b0;
        rx_enable = 1'b1; dmarq = 1'b1;
        wait_ack();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) send_word(16'h3C00 + 16'(i * 16'h0203));
        host_stop_req = 1'b1;
        gap = 0;
        fork
            begin
                while (!hrdy_n) @(negedge clk);
                while (!stop_o) begin @(negedge clk); gap++; end
            end
            begin
                @(negedge clk);
                send_word(16'h7001);
                send_word(16'h7002);
            end
        join
        checks++;
        if (gap < T_RP) begin
            errors++;
            $display("FAIL R6 pause gap actual=%0d expected>=%0d", gap, T_RP);
        end
        check("R6 ready off at stop", hrdy_n, 1);
        repeat (4) @(negedge clk);
        dmarq = 1'b0;
        while (!done_flag) @(negedge clk);
        check("R7 late words counted", got_words, 6);
        check("R10 origin host end", got_by_host, 1);
        check("R7 queue drained", exp_q.size(), 0);
        host_stop_req = 1'b0; rx_enable = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle after bursts", {dmack_n, stop_o, hrdy_n}, 3'b101);
        finish_run();
    end
endmodule